// File: doc/BRIEF.md
# Variable-Width Transmit Word Packer

This block sits between a register write port and the transmit FIFO of a serial flash controller. Software writes data words to one of four addresses. The address it picks tells the block how many bytes of the word are valid: four, one, two or three. So a transfer whose length is not a multiple of four needs no separate length register. The block turns each accepted write into one FIFO entry that holds a 2-bit byte count and the 32-bit data. The shifter downstream uses the count to stop after the right number of bytes.

A partial word may only enter the FIFO when the FIFO is empty. If a partial write arrives while older words are still queued, it is parked in a one-entry hold register. While the hold is occupied the write port reports not-ready. A full-word write that meets a full FIFO is dropped, and this raises a sticky overflow flag.

On the receive side the block remembers the count of the most recently pushed entry. A final received word with fewer than four valid bytes arrives in the upper byte lanes. The block shifts it down so those bytes are right-aligned, and the unused upper bytes read as zero.

Top module: `txw_packer`

## Requirements
- R1: A write to offset 0x1C with the FIFO not full pushes, in the same cycle, one entry with count code 0 (meaning four bytes) and the write data unchanged.
- R2: Writes to offsets 0x80, 0x84 and 0x88 produce entries with count codes 1, 2 and 3. The low 1, 2 or 3 byte lanes are kept, with the first byte in bits [7:0]. The remaining upper lanes of the pushed data are zero, whatever value the write carried there.
- R3: A write to offset 0x1C while the FIFO is full pushes nothing and sets the overflow flag. The flag stays set until reset.
- R4: A partial write accepted while the FIFO is not empty is parked, and wr_ready goes low on the next cycle. The parked entry is pushed unchanged in the first cycle in which fifo_empty is high. wr_ready then returns high in the cycle after that push.
- R5: A partial write accepted while the FIFO is empty and nothing is parked is pushed in the same cycle.
- R6: A write to any other offset pushes nothing and leaves the overflow flag unchanged.
- R7: tail_count shows the count code of the most recent pushed entry from the cycle after that push. It is 0 after reset.
- R8: When rx_last_in is high and tail_count is n (1 to 3), rx_data_out is rx_data_in shifted right by 8*(4-n) bits, with zeros in the upper lanes. Otherwise rx_data_out equals rx_data_in.
- R9: During and right after reset: wr_ready is 1, push_valid is 0, the overflow flag is 0 and tail_count is 0.
- R10: A write presented while wr_ready is low is not accepted. It produces no push, no overflow and no later effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| wr_ready | output | 1 | Low while a partial word is parked |
| fifo_full | input | 1 | Transmit FIFO full |
| fifo_empty | input | 1 | Transmit FIFO empty |
| push_valid | output | 1 | Push one entry into the FIFO |
| push_count | output | 2 | Byte count code of the entry (0 means four) |
| push_data | output | 32 | Data of the entry |
| ovf_flag | output | 1 | Sticky overflow flag |
| tail_count | output | 2 | Count code of the last pushed entry |
| rx_last_in | input | 1 | The received word is the final one of the transfer |
| rx_data_in | input | 32 | Raw received word |
| rx_data_out | output | 32 | Received word, right-aligned |

## Verification
The embedded properties are checked on every cycle. They cover these rules:
- No push happens into a full FIFO.
- A partial entry is pushed only into an empty FIFO, and its unused upper lanes are clean.
- The overflow flag never clears once set.
- A parked entry stays put until the FIFO drains.
- tail_count follows the last push.

Other behaviour depends on a FIFO occupancy that evolves over time, so only the bench scenarios can show it. The bench fills the modelled FIFO to its 63-word limit to trigger an overflow. It drains a queue underneath a parked partial word and checks the release cycle. It presents writes while the port is stalled. It checks that reads from the receive side are aligned for every tail count.

// File: rtl/txw_pkg.sv
package txw_pkg;

    localparam int DATA_W   = 32;
    localparam int LANE_W   = 8;
    localparam int LANES    = DATA_W / LANE_W;
    localparam int CNT_W    = $clog2(LANES);

    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_FULL = 2'd1,
        WK_PART = 2'd2
    } wr_kind_e;

    typedef struct packed {
        wr_kind_e         kind;
        logic [CNT_W-1:0] cnt;
    } wr_dec_t;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] data;
    } tx_entry_t;

    // Keep the low cnt lanes, zero the rest; cnt of 0 keeps every lane.
    function automatic logic [DATA_W-1:0] keep_low_lanes(
        input logic [DATA_W-1:0] d, input logic [CNT_W-1:0] cnt);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            if (cnt == '0 || i < int'(cnt))
                r[i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
            else
                r[i*LANE_W +: LANE_W] = '0;
        end
        return r;
    endfunction

    // Move the cnt uppermost lanes down to lane 0; cnt of 0 is a full word.
    function automatic logic [DATA_W-1:0] right_align(
        input logic [DATA_W-1:0] d, input logic [CNT_W-1:0] cnt);
        logic [DATA_W-1:0] r;
        if (cnt == '0)
            r = d;
        else
            r = d >> (LANE_W * (LANES - int'(cnt)));
        return r;
    endfunction

endpackage

// File: rtl/txw_addr_decode.sv
module txw_addr_decode
    import txw_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  OFF_FULL = 8'h1C,
    parameter logic [7:0]  OFF_P1   = 8'h80,
    parameter logic [7:0]  OFF_P2   = 8'h84,
    parameter logic [7:0]  OFF_P3   = 8'h88
) (
    input  logic [ADDR_W-1:0] addr,
    output wr_dec_t           dec
);
    localparam int NPART = LANES - 1;

    logic [NPART-1:0] part_hit;
    logic [ADDR_W-1:0] part_off [NPART];

    assign part_off[0] = ADDR_W'(OFF_P1);
    assign part_off[1] = ADDR_W'(OFF_P2);
    assign part_off[2] = ADDR_W'(OFF_P3);

    for (genvar g = 0; g < NPART; g++) begin : g_part
        assign part_hit[g] = (addr == part_off[g]);
    end

    always_comb begin
        dec.kind = WK_NONE;
        dec.cnt  = '0;
        if (addr == ADDR_W'(OFF_FULL)) begin
            dec.kind = WK_FULL;
        end else begin
            for (int i = 0; i < NPART; i++) begin
                if (part_hit[i]) begin
                    dec.kind = WK_PART;
                    dec.cnt  = CNT_W'(i + 1);
                end
            end
        end
    end

    always_comb begin
        a_r2_one_hit: assert ($onehot0(part_hit));
    end
endmodule

// File: rtl/txw_hold_ctl.sv
module txw_hold_ctl
    import txw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  wr_dec_t           dec,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    output logic              wr_ready,
    output logic              push_valid,
    output tx_entry_t         push_entry,
    output logic              ovf_flag
);
    logic      hold_v;
    tx_entry_t hold_q;
    logic      accept;
    logic      capture;
    logic      ovf_set;
    tx_entry_t new_entry;

    assign wr_ready = !hold_v;
    assign accept   = wr_en && wr_ready;

    always_comb begin
        new_entry.cnt  = dec.cnt;
        new_entry.data = keep_low_lanes(wr_data, dec.cnt);
    end

    always_comb begin
        push_valid = 1'b0;
        push_entry = '0;
        capture    = 1'b0;
        ovf_set    = 1'b0;
        if (hold_v) begin
            push_valid = fifo_empty;
            push_entry = hold_q;
        end else if (accept) begin
            case (dec.kind)
                WK_FULL: begin
                    push_entry = new_entry;
                    push_valid = !fifo_full;
                    ovf_set    = fifo_full;
                end
                WK_PART: begin
                    push_entry = new_entry;
                    push_valid = fifo_empty;
                    capture    = !fifo_empty;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v   <= 1'b0;
            hold_q   <= '0;
            ovf_flag <= 1'b0;
        end else begin
            if (capture) begin
                hold_v <= 1'b1;
                hold_q <= new_entry;
            end else if (hold_v && fifo_empty) begin
                hold_v <= 1'b0;
            end
            if (ovf_set)
                ovf_flag <= 1'b1;
        end
    end

    a_r3_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
        push_valid |-> !fifo_full);
    a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);
    a_r4_partial_only_empty: assert property (@(posedge clk) disable iff (rst)
        (push_valid && push_entry.cnt != '0) |-> fifo_empty);
    a_r4_parked_stays: assert property (@(posedge clk) disable iff (rst)
        (hold_v && !fifo_empty) |=> (hold_v && $stable(hold_q)));
    a_r10_stall_no_new_push: assert property (@(posedge clk) disable iff (rst)
        (!wr_ready && push_valid) |-> (push_entry == hold_q));
endmodule

// File: rtl/txw_rx_align.sv
module txw_rx_align
    import txw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              push_valid,
    input  logic [CNT_W-1:0]  push_cnt,
    input  logic              rx_last_in,
    input  logic [DATA_W-1:0] rx_data_in,
    output logic [CNT_W-1:0]  tail_count,
    output logic [DATA_W-1:0] rx_data_out
);
    always_ff @(posedge clk) begin
        if (rst)
            tail_count <= '0;
        else if (push_valid)
            tail_count <= push_cnt;
    end

    assign rx_data_out = rx_last_in ? right_align(rx_data_in, tail_count) : rx_data_in;

    a_r7_tail_follows_push: assert property (@(posedge clk) disable iff (rst)
        push_valid |=> (tail_count == $past(push_cnt)));
    a_r7_tail_holds: assert property (@(posedge clk) disable iff (rst)
        !push_valid |=> $stable(tail_count));
endmodule

// File: rtl/txw_packer.sv
module txw_packer
    import txw_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    output logic              push_valid,
    output logic [CNT_W-1:0]  push_count,
    output logic [DATA_W-1:0] push_data,
    output logic              ovf_flag,
    output logic [CNT_W-1:0]  tail_count,
    input  logic              rx_last_in,
    input  logic [DATA_W-1:0] rx_data_in,
    output logic [DATA_W-1:0] rx_data_out
);
    wr_dec_t   dec;
    tx_entry_t entry;

    txw_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (wr_addr),
        .dec  (dec)
    );

    txw_hold_ctl u_hold (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .dec        (dec),
        .wr_data    (wr_data),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .wr_ready   (wr_ready),
        .push_valid (push_valid),
        .push_entry (entry),
        .ovf_flag   (ovf_flag)
    );

    assign push_count = entry.cnt;
    assign push_data  = entry.data;

    txw_rx_align u_rx (
        .clk         (clk),
        .rst         (rst),
        .push_valid  (push_valid),
        .push_cnt    (entry.cnt),
        .rx_last_in  (rx_last_in),
        .rx_data_in  (rx_data_in),
        .tail_count  (tail_count),
        .rx_data_out (rx_data_out)
    );

    a_r2_upper_lanes_clean: assert property (@(posedge clk) disable iff (rst)
        (push_valid && push_count == 2'd1) |-> (push_data[31:8] == '0));
    a_r9_ready_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (wr_ready && !ovf_flag && tail_count == '0));
endmodule

// File: tb/txw_packer_tb_top.sv
module txw_packer_tb_top;
    localparam int DEPTH = 63;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [31:0] wr_data;
    logic        wr_ready;
    logic        fifo_full;
    logic        fifo_empty;
    logic        push_valid;
    logic [1:0]  push_count;
    logic [31:0] push_data;
    logic        ovf_flag;
    logic [1:0]  tail_count;
    logic        rx_last_in;
    logic [31:0] rx_data_in;
    logic [31:0] rx_data_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference state
    int          m_cnt  = 0;
    bit          m_hv   = 0;
    logic [1:0]  m_hcnt = 0;
    logic [31:0] m_hdat = 0;
    bit          m_ovf  = 0;
    logic [1:0]  m_tail = 0;

    always #10 clk = ~clk;

    txw_packer dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .push_valid(push_valid), .push_count(push_count), .push_data(push_data),
        .ovf_flag(ovf_flag), .tail_count(tail_count), .rx_last_in(rx_last_in),
        .rx_data_in(rx_data_in), .rx_data_out(rx_data_out)
    );

    function automatic logic [31:0] exp_keep(input logic [31:0] d, input int n);
        logic [31:0] m;
        m = (n == 0) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 32'h1);
        return d & m;
    endfunction

    function automatic logic [31:0] exp_align(input logic [31:0] d, input bit last, input int n);
        logic [31:0] r;
        r = d;
        if (last && n != 0)
            for (int k = 0; k < 4 - n; k++) r = {8'h00, r[31:8]};
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit wen, input logic [7:0] addr, input logic [31:0] d,
                       input bit pop, input bit last, input logic [31:0] rxd);
        bit e_push, cap, oset;
        logic [1:0] e_cnt;
        logic [31:0] e_dat;
        int n;
        bit is_full, is_part;
        string tag;
        @(negedge clk);
        fifo_full  = (m_cnt == DEPTH);
        fifo_empty = (m_cnt == 0);
        wr_en = wen; wr_addr = addr; wr_data = d;
        rx_last_in = last; rx_data_in = rxd;
        is_full = (addr == 8'h1C);
        n = (addr == 8'h80) ? 1 : (addr == 8'h84) ? 2 : (addr == 8'h88) ? 3 : 0;
        is_part = (n != 0);
        e_push = 0; cap = 0; oset = 0; e_cnt = 0; e_dat = 0; tag = "R6";
        if (m_hv) begin
            tag = wen ? "R10" : "R4";
            e_push = (m_cnt == 0); e_cnt = m_hcnt; e_dat = m_hdat;
        end else if (wen && is_full) begin
            if (m_cnt == DEPTH) begin oset = 1; tag = "R3"; end
            else begin e_push = 1; e_dat = d; tag = "R1"; end
        end else if (wen && is_part) begin
            e_cnt = 2'(n); e_dat = exp_keep(d, n);
            if (m_cnt == 0) begin e_push = 1; tag = "R5"; end
            else begin cap = 1; tag = "R4"; end
        end
        #5;
        chk({tag, " push_valid"}, 64'(push_valid), 64'(e_push));
        if (e_push) begin
            chk({tag, " R2 push_count"}, 64'(push_count), 64'(e_cnt));
            chk({tag, " R2 push_data"}, 64'(push_data), 64'(e_dat));
        end
        chk("R4 wr_ready", 64'(wr_ready), 64'(!m_hv));
        chk("R3 ovf_flag", 64'(ovf_flag), 64'(m_ovf));
        chk("R7 tail_count", 64'(tail_count), 64'(m_tail));
        chk("R8 rx_data_out", 64'(rx_data_out), 64'(exp_align(rxd, last, int'(m_tail))));
        @(posedge clk);
        #1;
        if (m_hv && e_push) m_hv = 0;
        if (cap) begin m_hv = 1; m_hcnt = e_cnt; m_hdat = e_dat; end
        if (oset) m_ovf = 1;
        if (e_push) m_tail = e_cnt;
        m_cnt = m_cnt + int'(e_push) - int'(pop && m_cnt > 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1; wr_en = 0; wr_addr = 0; wr_data = 0;
        fifo_full = 0; fifo_empty = 1; rx_last_in = 1; rx_data_in = 32'hA1B2_C3D4;
        repeat (3) @(posedge clk);
        #5;
        // R9: reset state
        chk("R9 wr_ready", 64'(wr_ready), 64'd1);
        chk("R9 push_valid", 64'(push_valid), 64'd0);
        chk("R9 ovf_flag", 64'(ovf_flag), 64'd0);
        chk("R9 tail_count", 64'(tail_count), 64'd0);
        @(negedge clk); rst = 0;

        // R1 / R5 / R2 / R8 directed, FIFO empty
        cyc(1, 8'h1C, 32'h1122_3344, 1, 1, 32'hDEAD_BEEF);
        cyc(1, 8'h80, 32'hFFFF_FF5A, 1, 1, 32'h7700_0000);
        cyc(0, 8'h00, 0, 1, 1, 32'h7700_0000);
        cyc(1, 8'h84, 32'hABCD_1234, 1, 1, 32'h5566_0000);
        cyc(0, 8'h00, 0, 1, 1, 32'h5566_0000);
        cyc(1, 8'h88, 32'h99AA_BBCC, 1, 1, 32'h1234_5678);
        cyc(0, 8'h00, 0, 1, 1, 32'h1234_5678);
        cyc(0, 8'h00, 0, 0, 0, 32'h1234_5678);
        // R6: unknown offsets
        cyc(1, 8'h20, 32'hCAFE_F00D, 0, 0, 0);
        cyc(1, 8'h81, 32'hCAFE_F00D, 0, 0, 0);
        // R4: partial behind queued words, then R10 stalled writes
        cyc(1, 8'h1C, 32'h0000_0001, 0, 0, 0);
        cyc(1, 8'h1C, 32'h0000_0002, 0, 0, 0);
        cyc(1, 8'h84, 32'hEEEE_7788, 0, 0, 0);
        cyc(1, 8'h1C, 32'h0BAD_0BAD, 0, 0, 0);
        cyc(1, 8'h80, 32'h0BAD_0BAD, 1, 0, 0);
        cyc(0, 8'h00, 0, 1, 0, 0);
        cyc(1, 8'h1C, 32'h0BAD_0BAD, 0, 0, 0);
        cyc(0, 8'h00, 0, 1, 1, 32'hF00D_0000);
        // R3: fill to full then overflow
        for (int i = 0; i < DEPTH; i++) cyc(1, 8'h1C, 32'(i), 0, 0, 0);
        cyc(1, 8'h1C, 32'hFFFF_0000, 0, 0, 0);
        cyc(1, 8'h1C, 32'hFFFF_0001, 1, 0, 0);
        for (int i = 0; i < DEPTH + 2; i++) cyc(0, 8'h00, 0, 1, 0, 0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            int s;
            s = int'($urandom_range(0, 5));
            a = (s == 0) ? 8'h80 : (s == 1) ? 8'h84 : (s == 2) ? 8'h88 :
                (s == 3) ? 8'h40 : 8'h1C;
            cyc(($urandom_range(0, 9) < 7), a, $urandom(), ($urandom_range(0, 9) < 4),
                $urandom_range(0, 1) == 1, $urandom());
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule